// File: doc/BRIEF.md
# Write-back MSI snoop controller

This block keeps one small direct-mapped, write-back cache coherent with its peers on a shared, atomic bus. Every line is in one of three states: invalid (holds nothing), shared (clean, read-only, other caches may hold copies) or exclusive (the only copy, writable, dirty). Processor reads and writes that hit are served in the request cycle with no bus activity. Misses, and writes to lines that are not exclusive, request the bus and place a read miss or a write miss once the grant arrives. If a dirty line has to be evicted first, its write-back takes a separate bus tenure ahead of the miss.

The controller also watches the misses that other caches place on the bus. When such a miss hits a line held here, the line is downgraded or invalidated. If the line is exclusive, the controller drives the dirty word onto the bus and tells memory to abort its own reply, all within the snooped cycle. A snoop always wins over a processor access in the same cycle. A snoop that changes the line a pending miss depends on sends that miss back to its start. The cache itself is written only in the cycle the grant arrives, so a restarted miss is worked out again from the line's new state.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: While and after reset every line is invalid. With no request present, `bus_req`, `cpu_ready`, `snp_abort` are 0 and `bus_cmd` is 0 (no command).
- R2: A processor read whose tag matches a shared or exclusive line raises `cpu_ready` in the request cycle, returns the line's word on `cpu_rdata` and makes no bus request.
- R3: A processor write whose tag matches an exclusive line raises `cpu_ready` in the request cycle, stores `cpu_wdata` in the line and makes no bus request.
- R4: A processor read that misses raises `bus_req`. In the grant cycle it drives `bus_cmd` = 1 (read miss) with `bus_addr` = `cpu_addr`, returns `bus_rdata` on `cpu_rdata` with `cpu_ready` = 1 and leaves the line shared.
- R5: A processor write to an invalid, shared or other-tag line is a write miss. In the grant cycle it drives `bus_cmd` = 2 with `bus_addr` = `cpu_addr`, raises `cpu_ready` and leaves the line exclusive holding `cpu_wdata`.
- R6: A miss whose line is exclusive with another tag first spends one grant on `bus_cmd` = 3 (write-back), with the victim address {old tag, index} and its word on `bus_wdata`. Only a later grant carries the miss, and `cpu_ready` stays 0 until that second tenure.
- R7: A snooped write miss (`snp_cmd` = 2) that hits a shared line makes it invalid, with no abort.
- R8: A snooped read miss (`snp_cmd` = 1) that hits an exclusive line raises `snp_abort` and drives the line's word on `snp_data` in the same cycle. The line becomes shared.
- R9: A snooped write miss that hits an exclusive line raises `snp_abort` with the word on `snp_data` in the same cycle. The line becomes invalid.
- R10: A snoop that misses, a read miss that hits a shared line, and any `snp_cmd` = 3 leave every line unchanged and keep `snp_abort` at 0.
- R11: When `snp_valid` and a processor request meet in the idle state, the snoop is handled. That cycle has no `cpu_ready` and no bus command, and the request is served afterwards.
- R12: A snoop that changes the line at the requested index while the controller waits for a grant restarts the pending miss from the new line state. A victim that has been downgraded is therefore not written back.
- R13: `bus_cmd` is non-zero only in a cycle with both `bus_req` and `bus_gnt` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address {tag, index} |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_ready` |
| cpu_ready | output | 1 | Access completes this cycle |
| bus_req | output | 1 | Request for a bus tenure |
| bus_gnt | input | 1 | Bus granted for this cycle |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Address of the placed command |
| bus_wdata | output | DATA_W | Write-back word |
| bus_rdata | input | DATA_W | Fill word returned in the grant cycle |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_abort | output | 1 | Memory must abort, this cache supplies the word |
| snp_data | output | DATA_W | Supplied dirty word |

## Verification
On every cycle the assertions check how the bus and processor outputs relate. Commands appear only under a grant, an abort only with a snooped miss, and a snoop suppresses processor completion and commands. A write-back is never the final tenure, and the kind of miss always matches the kind of access. Line state transitions are invisible at the ports until a later access, so the bench scenarios carry them: hit-or-miss outcomes after snoops, write-back ordering on replacement, and the restart that drops a write-back. A reference model checks these against random mixes of accesses and snoops.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WBACK  = 2'd3
    } bus_cmd_t;

    typedef enum logic [1:0] {
        FS_IDLE      = 2'd0,
        FS_WB_WAIT   = 2'd1,
        FS_MISS_WAIT = 2'd2
    } ctl_st_t;

    typedef enum logic [1:0] {
        LW_NONE = 2'd0,
        LW_HIT  = 2'd1,
        LW_DROP = 2'd2,
        LW_FILL = 2'd3
    } line_wr_t;

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_t          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_t          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_st_t          wr_st,
    input  logic              wr_tag_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_data_en,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    logic [1:0]        st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(g));

        // state bits reset to invalid; tag and data need no reset
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[g] <= LN_INV;
            end else if (sel) begin
                st_q[g] <= wr_st;
            end
        end

        always_ff @(posedge clk) begin
            if (sel && wr_tag_en) begin
                tag_q[g] <= wr_tag;
            end
            if (sel && wr_data_en) begin
                data_q[g] <= wr_data;
            end
        end
    end

    assign a_st   = line_st_t'(st_q[a_idx]);
    assign a_tag  = tag_q[a_idx];
    assign a_data = data_q[a_idx];
    assign b_st   = line_st_t'(st_q[b_idx]);
    assign b_tag  = tag_q[b_idx];
    assign b_data = data_q[b_idx];

endmodule

// File: rtl/msi_lookup.sv
module msi_lookup
    import msi_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  line_st_t         st,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic             present,
    output logic             owned
);
    logic tag_eq;

    assign tag_eq  = (line_tag == req_tag);
    assign present = tag_eq && (st != LN_INV);
    assign owned   = tag_eq && (st == LN_EXC);

endmodule

// File: rtl/msi_ctl_fsm.sv
module msi_ctl_fsm
    import msi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cpu_req,
    input  logic     cpu_we,
    input  logic     cpu_present,
    input  logic     cpu_owned,
    input  logic     victim_dirty,
    input  logic     snp_valid,
    input  logic     snp_same_line,
    input  logic     bus_gnt,
    output logic     cpu_ready,
    output logic     bus_req,
    output bus_cmd_t bus_cmd,
    output line_wr_t line_wr,
    output logic     fill_sel,
    output logic     wb_sel
);
    ctl_st_t state_q;
    ctl_st_t state_d;
    logic    hit_now;

    // writes need ownership, reads need any valid copy
    assign hit_now = cpu_we ? cpu_owned : cpu_present;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE: begin
                if (!snp_valid && cpu_req && !hit_now) begin
                    state_d = victim_dirty ? FS_WB_WAIT : FS_MISS_WAIT;
                end
            end
            FS_WB_WAIT: begin
                if (snp_valid) begin
                    if (snp_same_line) begin
                        state_d = FS_IDLE;
                    end
                end else if (bus_gnt) begin
                    state_d = FS_MISS_WAIT;
                end
            end
            FS_MISS_WAIT: begin
                if (snp_valid) begin
                    if (snp_same_line) begin
                        state_d = FS_IDLE;
                    end
                end else if (bus_gnt) begin
                    state_d = FS_IDLE;
                end
            end
            default: state_d = FS_IDLE;
        endcase
    end

    always_comb begin
        cpu_ready = 1'b0;
        bus_req   = 1'b0;
        bus_cmd   = BC_NONE;
        line_wr   = LW_NONE;
        fill_sel  = 1'b0;
        wb_sel    = 1'b0;
        unique case (state_q)
            FS_IDLE: begin
                if (!snp_valid && cpu_req && hit_now) begin
                    cpu_ready = 1'b1;
                    if (cpu_we) begin
                        line_wr = LW_HIT;
                    end
                end
            end
            FS_WB_WAIT: begin
                bus_req = 1'b1;
                if (!snp_valid && bus_gnt) begin
                    bus_cmd = BC_WBACK;
                    wb_sel  = 1'b1;
                    line_wr = LW_DROP;
                end
            end
            FS_MISS_WAIT: begin
                bus_req = 1'b1;
                if (!snp_valid && bus_gnt) begin
                    bus_cmd   = cpu_we ? BC_WRMISS : BC_RDMISS;
                    line_wr   = LW_FILL;
                    fill_sel  = !cpu_we;
                    cpu_ready = 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_abort,
    output logic [DATA_W-1:0] snp_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  cpu_idx, snp_idx;
    logic [TAG_W-1:0]  cpu_tag, snp_tag;
    line_st_t          a_st, b_st, wr_st;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [DATA_W-1:0] a_data, b_data, wr_data;
    logic              cpu_present, cpu_owned, snp_present, snp_owned;
    logic              victim_dirty, snp_miss_cmd, snp_upd, snp_same_line;
    logic              wr_en, wr_tag_en, wr_data_en, fill_sel, wb_sel;
    logic [IDX_W-1:0]  wr_idx;
    bus_cmd_t          cmd;
    line_wr_t          line_wr;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

    msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .a_idx(cpu_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
        .b_idx(snp_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st),
        .wr_tag_en(wr_tag_en), .wr_tag(cpu_tag),
        .wr_data_en(wr_data_en), .wr_data(wr_data)
    );

    msi_lookup #(.TAG_W(TAG_W)) cpu_look_i (
        .st(a_st), .line_tag(a_tag), .req_tag(cpu_tag),
        .present(cpu_present), .owned(cpu_owned)
    );

    msi_lookup #(.TAG_W(TAG_W)) snp_look_i (
        .st(b_st), .line_tag(b_tag), .req_tag(snp_tag),
        .present(snp_present), .owned(snp_owned)
    );

    // an exclusive line holding another tag must leave before the miss
    assign victim_dirty = (a_st == LN_EXC) && !cpu_present;

    // only other caches' misses matter; their write-backs are ignored
    assign snp_miss_cmd = snp_valid &&
                          ((bus_cmd_t'(snp_cmd) == BC_RDMISS) ||
                           (bus_cmd_t'(snp_cmd) == BC_WRMISS));
    assign snp_upd       = snp_miss_cmd && snp_present &&
                           ((bus_cmd_t'(snp_cmd) == BC_WRMISS) || snp_owned);
    assign snp_same_line = snp_upd && (snp_idx == cpu_idx);
    assign snp_abort     = snp_miss_cmd && snp_owned;
    assign snp_data      = snp_abort ? b_data : '0;

    msi_ctl_fsm fsm_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_present(cpu_present), .cpu_owned(cpu_owned),
        .victim_dirty(victim_dirty),
        .snp_valid(snp_valid), .snp_same_line(snp_same_line),
        .bus_gnt(bus_gnt),
        .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_cmd(cmd),
        .line_wr(line_wr), .fill_sel(fill_sel), .wb_sel(wb_sel)
    );

    // single write port: a snoop update wins over any processor-side write
    always_comb begin
        wr_en      = 1'b0;
        wr_idx     = cpu_idx;
        wr_st      = LN_INV;
        wr_tag_en  = 1'b0;
        wr_data_en = 1'b0;
        wr_data    = cpu_wdata;
        if (snp_upd) begin
            wr_en  = 1'b1;
            wr_idx = snp_idx;
            wr_st  = (bus_cmd_t'(snp_cmd) == BC_WRMISS) ? LN_INV : LN_SHR;
        end else begin
            unique case (line_wr)
                LW_HIT: begin
                    wr_en      = 1'b1;
                    wr_st      = LN_EXC;
                    wr_data_en = 1'b1;
                end
                LW_DROP: begin
                    wr_en = 1'b1;
                    wr_st = LN_INV;
                end
                LW_FILL: begin
                    wr_en      = 1'b1;
                    wr_st      = cpu_we ? LN_EXC : LN_SHR;
                    wr_tag_en  = 1'b1;
                    wr_data_en = 1'b1;
                    wr_data    = cpu_we ? cpu_wdata : bus_rdata;
                end
                default: ;
            endcase
        end
    end

    assign bus_cmd   = cmd;
    assign bus_addr  = (cmd == BC_NONE) ? '0 :
                       (wb_sel ? {a_tag, cpu_idx} : cpu_addr);
    assign bus_wdata = (cmd == BC_WBACK) ? a_data : '0;
    assign cpu_rdata = !cpu_ready ? '0 : (fill_sel ? bus_rdata : a_data);

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_req,
    input logic       cpu_we,
    input logic       cpu_ready,
    input logic       bus_req,
    input logic       bus_gnt,
    input logic [1:0] bus_cmd,
    input logic       snp_valid,
    input logic [1:0] snp_cmd,
    input logic       snp_abort
);
    // R13: a command is placed only in a granted, requested cycle
    a_r13_cmd_under_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != 2'd0) |-> (bus_req && bus_gnt));

    // R8 / R9: memory abort only answers another cache's miss
    a_r8_abort_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        snp_abort |-> (snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2)));

    // R11: a snoop cycle neither completes an access nor places a command
    a_r11_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> (!cpu_ready && bus_cmd == 2'd0));

    // R6: the write-back tenure never ends the access
    a_r6_wb_not_last: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == 2'd3) |-> !cpu_ready);

    // R6: after the write-back the controller keeps asking for the bus
    a_r6_wb_then_req: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == 2'd3) |=> bus_req);

    // R4: a read miss belongs to a read and completes it
    a_r4_rdmiss_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == 2'd1) |-> (cpu_req && !cpu_we && cpu_ready));

    // R5: a write miss belongs to a write and completes it
    a_r5_wrmiss_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == 2'd2) |-> (cpu_req && cpu_we && cpu_ready));

    // R2: completion only answers a request
    a_r2_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk chk_i (.*);

// File: tb/msi_snoop_ctrl_tb.sv
module msi_snoop_ctrl_tb_top;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int IW = 3;
    localparam int TW = AW - IW;
    localparam int NL = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cpu_req, cpu_we, cpu_ready;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata, cpu_rdata;
    logic          bus_req, bus_gnt;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          snp_valid, snp_abort;
    logic [1:0]    snp_cmd;
    logic [AW-1:0] snp_addr;
    logic [DW-1:0] snp_data;

    logic [DW-1:0] tb_mem [1 << AW];
    logic [1:0]    m_st   [NL];
    logic [TW-1:0] m_tag  [NL];
    logic [DW-1:0] m_data [NL];

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    assign bus_rdata = tb_mem[bus_addr];

    msi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_abort(snp_abort), .snp_data(snp_data)
    );

    task automatic chk_eq(input string rq, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk_addr(input int tg, input int ix);
        return {TW'(tg), IW'(ix)};
    endfunction

    task automatic cpu_op(input logic we, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, input int gdel);
        logic [IW-1:0] ix;
        logic [TW-1:0] tg;
        logic [AW-1:0] vic_a, wb_a, ms_a;
        logic [DW-1:0] exp_rd, wb_d, got_rd;
        logic [1:0]    ms_cmd;
        bit            hit, vic, done, first, order_ok;
        int            n_wb, n_miss, waitc;
        string         rq;
        ix     = a[IW-1:0];
        tg     = a[AW-1:IW];
        hit    = we ? (m_st[ix] == 2'd2 && m_tag[ix] == tg)
                    : (m_st[ix] != 2'd0 && m_tag[ix] == tg);
        vic    = !hit && (m_st[ix] == 2'd2);
        vic_a  = {m_tag[ix], ix};
        exp_rd = hit ? m_data[ix] : tb_mem[a];
        rq     = hit ? (we ? "R3" : "R2") : (we ? "R5" : "R4");
        n_wb = 0; n_miss = 0; waitc = 0;
        done = 0; first = 0; order_ok = 1;
        wb_a = '0; ms_a = '0; wb_d = '0; got_rd = '0; ms_cmd = '0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        for (int c = 0; c < 40 && !done; c++) begin
            if (c > 0) @(negedge clk);
            bus_gnt = 1'b0;
            #1;
            if (bus_req) begin
                if (waitc >= gdel) begin
                    bus_gnt = 1'b1;
                    #1;
                end
                waitc++;
            end
            if (bus_cmd != 2'd0 && !bus_gnt) chk_eq("R13", "command without grant", bus_cmd, 0);
            if (bus_cmd == 2'd3) begin
                n_wb++; wb_a = bus_addr; wb_d = bus_wdata;
            end else if (bus_cmd != 2'd0) begin
                n_miss++; ms_cmd = bus_cmd; ms_a = bus_addr;
                if (n_wb != (vic ? 1 : 0)) order_ok = 0;
            end
            if (cpu_ready) begin
                done = 1; first = (c == 0); got_rd = cpu_rdata;
            end
        end
        @(negedge clk);
        cpu_req = 1'b0; bus_gnt = 1'b0;
        chk_eq(rq, "access completed", done, 1);
        if (hit) begin
            chk_eq(rq, "ready in request cycle", first, 1);
            chk_eq(rq, "bus tenures on hit", n_wb + n_miss, 0);
        end else begin
            chk_eq(rq, "miss tenures", n_miss, 1);
            chk_eq(rq, "miss command", ms_cmd, we ? 2 : 1);
            chk_eq(rq, "miss address", ms_a, a);
            chk_eq("R6", "write-back tenures", n_wb, vic ? 1 : 0);
            if (vic) begin
                chk_eq("R6", "victim address", wb_a, vic_a);
                chk_eq("R6", "victim word", wb_d, m_data[ix]);
                chk_eq("R6", "write-back precedes miss", order_ok, 1);
                tb_mem[vic_a] = m_data[ix];
            end
        end
        if (!we) chk_eq(rq, "read word", got_rd, exp_rd);
        if (!hit) begin
            m_tag[ix]  = tg;
            m_st[ix]   = we ? 2'd2 : 2'd1;
            m_data[ix] = we ? wd : exp_rd;
        end else if (we) begin
            m_data[ix] = wd;
        end
    endtask

    task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a);
        logic [IW-1:0] ix;
        bit            hit, ab;
        string         rq;
        ix  = a[IW-1:0];
        hit = (m_st[ix] != 2'd0) && (m_tag[ix] == a[AW-1:IW]);
        ab  = hit && (m_st[ix] == 2'd2) && (cmd == 2'd1 || cmd == 2'd2);
        rq  = ab ? ((cmd == 2'd1) ? "R8" : "R9")
                 : ((hit && cmd == 2'd2) ? "R7" : "R10");
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
        #1;
        chk_eq(rq, "abort flag", snp_abort, ab);
        if (ab) chk_eq(rq, "supplied word", snp_data, m_data[ix]);
        @(negedge clk);
        snp_valid = 1'b0;
        if (ab) tb_mem[a] = m_data[ix];
        if (hit && cmd == 2'd2) m_st[ix] = 2'd0;
        else if (ab) m_st[ix] = 2'd1;
    endtask

    // R11: snoop and processor request in the same idle cycle
    task automatic snoop_vs_hit(input logic [AW-1:0] a, input logic [AW-1:0] other);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = other;
        #1;
        chk_eq("R11", "ready while snooping", cpu_ready, 0);
        chk_eq("R11", "command while snooping", bus_cmd, 0);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk_eq("R11", "ready after snoop", cpu_ready, 1);
        chk_eq("R11", "read word after snoop", cpu_rdata, m_data[a[IW-1:0]]);
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    // R12: a snoop downgrades the victim while the write-back waits for the bus
    task automatic restart_case(input logic [AW-1:0] owner_a, input logic [AW-1:0] new_a);
        logic [IW-1:0] ix;
        bit            got;
        ix = owner_a[IW-1:0];
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = new_a; bus_gnt = 1'b0;
        @(negedge clk);
        #1;
        chk_eq("R12", "request while write-back pending", bus_req, 1);
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = owner_a;
        #1;
        chk_eq("R12", "abort during pending miss", snp_abort, 1);
        chk_eq("R12", "supplied word", snp_data, m_data[ix]);
        @(negedge clk);
        snp_valid = 1'b0;
        tb_mem[owner_a] = m_data[ix];
        got = 0;
        for (int c = 0; c < 10 && !got; c++) begin
            if (c > 0) @(negedge clk);
            bus_gnt = 1'b0;
            #1;
            if (bus_req) begin
                bus_gnt = 1'b1;
                #1;
                got = 1;
                chk_eq("R12", "first command after restart", bus_cmd, 1);
                chk_eq("R12", "restarted miss address", bus_addr, new_a);
                chk_eq("R12", "restarted read word", cpu_rdata, tb_mem[new_a]);
            end
        end
        chk_eq("R12", "restarted miss reached bus", got, 1);
        @(negedge clk);
        cpu_req = 1'b0; bus_gnt = 1'b0;
        m_st[ix] = 2'd1; m_tag[ix] = new_a[AW-1:IW]; m_data[ix] = tb_mem[new_a];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        for (int i = 0; i < (1 << AW); i++) tb_mem[i] = DW'(i * 97 + 13);
        for (int i = 0; i < NL; i++) begin
            m_st[i] = 2'd0; m_tag[i] = '0; m_data[i] = '0;
        end
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        bus_gnt = 1'b0; snp_valid = 1'b0; snp_cmd = '0; snp_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk_eq("R1", "bus request after reset", bus_req, 0);
        chk_eq("R1", "ready after reset", cpu_ready, 0);
        chk_eq("R1", "command after reset", bus_cmd, 0);
        chk_eq("R1", "abort after reset", snp_abort, 0);

        // R1/R4 then R2: first read misses, second hits
        cpu_op(1'b0, mk_addr(0, 1), '0, 1);
        cpu_op(1'b0, mk_addr(0, 1), '0, 0);
        // R5 on a shared line, then R3 hits
        cpu_op(1'b1, mk_addr(0, 1), 16'hA5A5, 2);
        cpu_op(1'b1, mk_addr(0, 1), 16'h5A5A, 0);
        cpu_op(1'b0, mk_addr(0, 1), '0, 0);
        // R8 then a write must miss again
        snoop(2'd1, mk_addr(0, 1));
        cpu_op(1'b1, mk_addr(0, 1), 16'h1111, 0);
        // R9 then a read misses
        snoop(2'd2, mk_addr(0, 1));
        cpu_op(1'b0, mk_addr(0, 1), '0, 0);
        // R7 then a read misses
        snoop(2'd2, mk_addr(0, 1));
        cpu_op(1'b0, mk_addr(0, 1), '0, 1);
        // R10: write-back command and read miss on shared line change nothing
        snoop(2'd3, mk_addr(0, 1));
        snoop(2'd1, mk_addr(0, 1));
        cpu_op(1'b0, mk_addr(0, 1), '0, 0);
        // R6: exclusive victim evicted by a read of another tag
        cpu_op(1'b1, mk_addr(1, 1), 16'hBEEF, 0);
        cpu_op(1'b0, mk_addr(0, 1), '0, 3);
        // R11
        snoop_vs_hit(mk_addr(0, 1), mk_addr(31, 6));
        // R12
        cpu_op(1'b1, mk_addr(1, 5), 16'h1234, 0);
        restart_case(mk_addr(1, 5), mk_addr(2, 5));
        cpu_op(1'b0, mk_addr(1, 5), '0, 0);

        for (int k = 0; k < 500; k++) begin
            int ix, tg, sel;
            ix  = int'($urandom % NL);
            tg  = int'($urandom % 3);
            sel = int'($urandom % 10);
            if (sel < 7) cpu_op(sel < 4, mk_addr(tg, ix), DW'($urandom), int'($urandom % 4));
            else         snoop(2'(1 + ($urandom % 3)), mk_addr(tg, ix));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule